// File: doc/BRIEF.md
# Time-Domain Winner-Take-All Tree

The block picks the strongest of `N_CAND` candidate match scores by turning each score into a timing edge and letting the edges race. A ramp counter shared by every candidate starts when the evaluation enable goes high. Each candidate raises its arrival line once the ramp has come down far enough to meet its score, so a larger score arrives after fewer cycles. A binary tree of two-input arbiters then decides the winner. Each arbiter latches which of its two inputs rose first and passes the OR of both inputs to the level above. Nothing feeds back down the tree.

The flags along the winning path, read from the root down to the leaves, give the winner's binary index. A one-cycle valid strobe marks the first cycle in which that index can be used. The block also forms a system-wide address from a chip index, a core index and the local index. If the ramp runs out before any candidate arrives, a separate no-winner strobe pulses instead of the valid strobe. When the enable is dropped, the ramp and every flag are cleared, ready for the next evaluation.

Top module: `wta_race_top`

## Requirements
- R1: Candidate i arrives at ramp step `MAX - score_i + 1`, where MAX = 2^SCORE_W - 1 and the ramp steps once per cycle from 0 after `eval_i` rises. `valid_o` therefore goes high `MAX - s + 2` clock edges after the first edge with `eval_i` high, where s is the largest score.
- R2: `win_addr_o` carries the index of the candidate with the largest score. Candidate i occupies bits `[i*SCORE_W +: SCORE_W]` of `score_i`.
- R3: When several candidates share the largest score, the lowest index wins.
- R4: `valid_o` pulses for exactly one cycle per evaluation. `win_addr_o` holds its value from that cycle for as long as `eval_i` stays high.
- R5: While `eval_i` is low, `valid_o` and `none_o` stay low and `win_addr_o` reads 0.
- R6: A score of 0 never arrives. If every score is 0, `none_o` pulses once, `MAX + 1` edges after the first edge with `eval_i` high, and `valid_o` does not pulse.
- R7: `glob_addr_o` equals `{chip_idx_i, core_idx_i, win_addr_o}`, with the chip index as the most significant field.
- R8: Dropping `eval_i` and raising it again starts a new evaluation, whose result depends only on the current scores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| eval_i | input | 1 | Arms the ramp and the arbiter tree |
| score_i | input | N_CAND*SCORE_W | Packed candidate scores |
| chip_idx_i | input | CHIP_W | Chip field of the global address |
| core_idx_i | input | CORE_W | Core field of the global address |
| win_addr_o | output | log2(N_CAND) | Local index of the winner |
| glob_addr_o | output | CHIP_W+CORE_W+log2(N_CAND) | Concatenated global winner address |
| valid_o | output | 1 | One-cycle strobe when a winner is decided |
| none_o | output | 1 | One-cycle strobe when the ramp ends with no arrival |

## Verification
The assertions assume that `score_i` holds steady while `eval_i` is high, so that an arrival, once raised, stays raised until the enable falls. The bench only changes scores and indices while the enable is low, and leaves at least one low cycle between evaluations. Random scores are sometimes drawn from a narrow top band so that ties and near-ties happen often. Directed cases cover the extreme scores, a winner at either end of the array, and the all-zero case.

// File: rtl/wta_pkg.sv
package wta_pkg;
  typedef struct packed {
    logic taken;
    logic hi_won;
  } node_st_t;
endpackage

// File: rtl/wta_ramp.sv
module wta_ramp #(
  parameter int N_CAND  = 8,
  parameter int SCORE_W = 6
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      arm_i,
  input  logic [N_CAND*SCORE_W-1:0] score_i,
  output logic [N_CAND-1:0]         arrive_o,
  output logic                      at_top_o
);
  localparam logic [SCORE_W-1:0] TOP = '1;

  logic [SCORE_W-1:0] cnt_q;
  logic [SCORE_W-1:0] level;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (!arm_i)       cnt_q <= '0;
    else if (cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
  end

  // descending threshold: larger score crosses first
  assign level    = TOP - cnt_q;
  assign at_top_o = (cnt_q == TOP);

  for (genvar i = 0; i < N_CAND; i++) begin : g_cmp
    assign arrive_o[i] = arm_i && (score_i[i*SCORE_W +: SCORE_W] > level);

    p_arrive_sticky_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (arm_i && arrive_o[i]) |=> (!arm_i || arrive_o[i]));
  end

  p_zero_never_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_i && !at_top_o) |=> (cnt_q != '0 || !arm_i));
endmodule

// File: rtl/wta_node.sv
module wta_node
  import wta_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic lo_i,
  input  logic hi_i,
  output logic any_o,
  output logic hi_won_o
);
  node_st_t st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     st_q <= '0;
    else if (!arm_i)                 st_q <= '0;
    else if (!st_q.taken && (lo_i || hi_i)) begin
      st_q.taken  <= 1'b1;
      st_q.hi_won <= !lo_i;  // tie goes to the lower side
    end
  end

  assign any_o    = lo_i | hi_i;
  assign hi_won_o = st_q.hi_won;

  p_tie_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_i && !st_q.taken && lo_i) |=> !hi_won_o);

  p_flag_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_i && st_q.taken) |=> $stable(hi_won_o));

  p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_i |=> !hi_won_o);
endmodule

// File: rtl/wta_tree.sv
module wta_tree #(
  parameter int N_CAND = 8,
  localparam int DEPTH = $clog2(N_CAND)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic [N_CAND-1:0] arrive_i,
  output logic             root_o,
  output logic [DEPTH-1:0] addr_o
);
  logic [N_CAND-1:0] up  [0:DEPTH];
  logic [N_CAND-1:0] flg [1:DEPTH];

  assign up[0] = arrive_i;

  for (genvar l = 1; l <= DEPTH; l++) begin : g_lvl
    localparam int NODES = N_CAND >> l;
    assign up[l][N_CAND-1:NODES]  = '0;
    assign flg[l][N_CAND-1:NODES] = '0;
    for (genvar j = 0; j < NODES; j++) begin : g_node
      wta_node u_node (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .arm_i    (arm_i),
        .lo_i     (up[l-1][2*j]),
        .hi_i     (up[l-1][2*j+1]),
        .any_o    (up[l][j]),
        .hi_won_o (flg[l][j])
      );
    end
  end

  assign root_o = up[DEPTH][0];

  // follow the latched flags from the root down
  always_comb begin
    addr_o = '0;
    for (int l = DEPTH; l >= 1; l--) begin
      addr_o = (addr_o << 1) | DEPTH'(flg[l][addr_o]);
    end
  end
endmodule

// File: rtl/wta_race_top.sv
module wta_race_top #(
  parameter int N_CAND  = 8,
  parameter int SCORE_W = 6,
  parameter int CHIP_W  = 2,
  parameter int CORE_W  = 2,
  localparam int IDX_W  = $clog2(N_CAND),
  localparam int GLOB_W = CHIP_W + CORE_W + IDX_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      eval_i,
  input  logic [N_CAND*SCORE_W-1:0] score_i,
  input  logic [CHIP_W-1:0]         chip_idx_i,
  input  logic [CORE_W-1:0]         core_idx_i,
  output logic [IDX_W-1:0]          win_addr_o,
  output logic [GLOB_W-1:0]         glob_addr_o,
  output logic                      valid_o,
  output logic                      none_o
);
  logic [N_CAND-1:0] arrive;
  logic              at_top, root;
  logic              root_seen_q, top_seen_q, valid_q, none_q;

  wta_ramp #(.N_CAND(N_CAND), .SCORE_W(SCORE_W)) u_ramp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .arm_i    (eval_i),
    .score_i  (score_i),
    .arrive_o (arrive),
    .at_top_o (at_top)
  );

  wta_tree #(.N_CAND(N_CAND)) u_tree (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .arm_i    (eval_i),
    .arrive_i (arrive),
    .root_o   (root),
    .addr_o   (win_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      root_seen_q <= 1'b0;
      top_seen_q  <= 1'b0;
      valid_q     <= 1'b0;
      none_q      <= 1'b0;
    end else begin
      root_seen_q <= eval_i && (root_seen_q || root);
      top_seen_q  <= eval_i && (top_seen_q || at_top);
      valid_q     <= eval_i && root && !root_seen_q;
      none_q      <= eval_i && at_top && !root && !top_seen_q;
    end
  end

  assign valid_o     = valid_q;
  assign none_o      = none_q;
  assign glob_addr_o = {chip_idx_i, core_idx_i, win_addr_o};

  p_one_strobe_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  p_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eval_i |=> (!valid_o && !none_o));

  p_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && none_o));

  p_winner_arrived_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && eval_i) |-> arrive[win_addr_o]);

  p_addr_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && eval_i) |=> $stable(win_addr_o));
endmodule

// File: tb/sim_wta_race_top.sv
module sim_wta_race_top;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int SW = 6;
  localparam int CW = 2;
  localparam int KW = 2;
  localparam int IW = $clog2(N);
  localparam int GW = CW + KW + IW;
  localparam int MAXV = (1 << SW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          eval = 1'b0;
  logic [N*SW-1:0] score = '0;
  logic [CW-1:0] chip = '0;
  logic [KW-1:0] core = '0;
  logic [IW-1:0] win_addr;
  logic [GW-1:0] glob_addr;
  logic          valid, none;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wta_race_top #(.N_CAND(N), .SCORE_W(SW), .CHIP_W(CW), .CORE_W(KW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .eval_i(eval), .score_i(score),
    .chip_idx_i(chip), .core_idx_i(core), .win_addr_o(win_addr),
    .glob_addr_o(glob_addr), .valid_o(valid), .none_o(none)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sc_at(input logic [N*SW-1:0] v, input int i);
    return int'(v[i*SW +: SW]);
  endfunction

  function automatic int exp_idx(input logic [N*SW-1:0] v);
    int best = 0;
    for (int i = 1; i < N; i++) if (sc_at(v, i) > sc_at(v, best)) best = i;
    return best;
  endfunction

  function automatic int exp_max(input logic [N*SW-1:0] v);
    return sc_at(v, exp_idx(v));
  endfunction

  task automatic run_eval(input logic [N*SW-1:0] v);
    int n_valid = 0, n_none = 0, k_valid = -1, k_none = -1;
    int addr_cap = 0, glob_cap = 0;
    bit held = 1'b1;
    int mx, ix;
    @(negedge clk);
    score = v;
    chip  = CW'($urandom);
    core  = KW'($urandom);
    @(negedge clk);
    eval = 1'b1;
    for (int k = 1; k <= MAXV + 4; k++) begin
      @(negedge clk);
      if (n_valid > 0 && int'(win_addr) != addr_cap) held = 1'b0;
      if (valid) begin
        n_valid++;
        if (k_valid < 0) begin
          k_valid  = k;
          addr_cap = int'(win_addr);
          glob_cap = int'(glob_addr);
        end
      end
      if (none) begin
        n_none++;
        if (k_none < 0) k_none = k;
      end
    end
    mx = exp_max(v);
    ix = exp_idx(v);
    if (mx == 0) begin
      chk(n_valid == 0, "R6 no valid", n_valid, 0);
      chk(n_none == 1, "R6 none count", n_none, 1);
      chk(k_none == MAXV + 1, "R6 none timing", k_none, MAXV + 1);
    end else begin
      chk(n_valid == 1, "R4 valid count", n_valid, 1);
      chk(n_none == 0, "R6 none absent", n_none, 0);
      chk(k_valid == MAXV - mx + 2, "R1 latency", k_valid, MAXV - mx + 2);
      chk(addr_cap == ix, "R2 R3 winner", addr_cap, ix);
      chk(held, "R4 addr hold", int'(win_addr), addr_cap);
      chk(glob_cap == int'({chip, core, IW'(ix)}), "R7 global addr",
          glob_cap, int'({chip, core, IW'(ix)}));
    end
    eval = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(!valid && !none && win_addr == '0, "R5 idle after drop",
        int'({valid, none, win_addr}), 0);
  endtask

  function automatic logic [N*SW-1:0] fill(input int val);
    logic [N*SW-1:0] v;
    for (int i = 0; i < N; i++) v[i*SW +: SW] = SW'(val);
    return v;
  endfunction

  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [N*SW-1:0] v;
    void'($urandom(32'd1234));
    #(CLK_PERIOD*3);
    @(negedge clk);
    chk(!valid && !none && win_addr == '0, "R5 reset state",
        int'({valid, none, win_addr}), 0);
    rst_n = 1'b1;

    // R5: scores present but enable low
    score = fill(40);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      chk(!valid && !none && win_addr == '0, "R5 eval low",
          int'({valid, none, win_addr}), 0);
    end

    v = fill(10); v[0*SW +: SW] = SW'(50);          run_eval(v); // R2 index 0
    v = fill(10); v[(N-1)*SW +: SW] = SW'(50);      run_eval(v); // R2 top index
    v = fill(20); v[3*SW +: SW] = SW'(MAXV);        run_eval(v); // R1 fastest
    v = fill(0);  v[5*SW +: SW] = SW'(1);           run_eval(v); // R1 slowest, R6
    run_eval(fill(0));                                            // R6 all zero
    run_eval(fill(33));                                           // R3 full tie
    v = fill(5); v[2*SW +: SW] = SW'(44); v[6*SW +: SW] = SW'(44); run_eval(v); // R3
    v = fill(5); v[6*SW +: SW] = SW'(44);           run_eval(v); // R8 rearm

    for (int t = 0; t < 40; t++) begin
      for (int i = 0; i < N; i++) begin
        if (t % 2 == 0) v[i*SW +: SW] = SW'(MAXV - 7 + ($urandom % 8));
        else            v[i*SW +: SW] = SW'($urandom);
      end
      run_eval(v);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule